// File: doc/BRIEF.md
# Encoded Interrupt Level Mask Unit

This block sits between two groups of encoded interrupt request inputs and the interrupt priority logic. Each group presents a 4-bit level code; the all-ones code means the group is idle. A 32-bit mask register holds one bit for every non-idle code of each group. Group 0 owns the upper half of the register and group 1 owns the lower half. In each half the code value counts down from the top bit.

Software masks a level by writing a 1 to the set port. A 0 in that write leaves the bit as it is. A level is unmasked only by writing a 1 to the matching bit of a separate clear port. This means a stray write of zero can never re-enable a level. A coarse enable per group, taken from a first-level mask elsewhere, gates each group before this register is consulted.

Each group produces a registered request flag and the level code that goes with it. The flag is asserted one clock after an enabled, non-idle, unmasked code is presented.

Top module: `lvl_mask_unit`

## Requirements
- R1: After reset every bit of the mask register is 0, so every level of both groups is accepted.
- R2: A set write (`set_we`=1) sets each mask bit whose `set_data` bit is 1. Bits whose `set_data` bit is 0 keep their value.
- R3: A clear write (`clr_we`=1) clears each mask bit whose `clr_data` bit is 1. A 0 in `clr_data` has no effect. Reading the clear register (`rd_sel`=1) always returns 0.
- R4: `rd_data` returns the mask register when `rd_sel`=0. A 1 in a bit means that level is masked and a 0 means it is accepted.
- R5: For group 0, code n (0 to 14) is governed by mask bit 31-n.
- R6: For group 1, code n (0 to 14) is governed by mask bit 15-n.
- R7: Bits 16 and 0 always read as 0, and set writes to those bits are ignored.
- R8: While a group's enable is 0, that group's request output is 0 whatever the mask holds.
- R9: Code 15 (4'b1111) on a group input is idle and never produces a request.
- R10: A group's request output is registered. It is 1 in the cycle after an enabled, non-idle, unmasked code is sampled, and the level output then carries that sampled code.
- R11: When a set write and a clear write hit the same bit in the same cycle, the bit ends up cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_we | input | 1 | Set-port write strobe |
| set_data | input | 32 | Bits to set in the mask |
| clr_we | input | 1 | Clear-port write strobe |
| clr_data | input | 32 | Bits to clear in the mask |
| rd_sel | input | 1 | Read select: 0 mask register, 1 clear register |
| rd_data | output | 32 | Read data for the selected register |
| g0_en | input | 1 | First-level enable for group 0 |
| g0_code | input | 4 | Group 0 encoded level |
| g1_en | input | 1 | First-level enable for group 1 |
| g1_code | input | 4 | Group 1 encoded level |
| g0_req | output | 1 | Group 0 masked request, registered |
| g0_level | output | 4 | Group 0 level code, registered |
| g1_req | output | 1 | Group 1 masked request, registered |
| g1_level | output | 4 | Group 1 level code, registered |

## Verification
The bench walks every code of each group with exactly one mask bit set. A design that maps codes in the wrong direction, or that uses the wrong half of the register, would pass the wrong code or block the wrong one. It writes zeros to both ports to catch a design that treats a 0 as a clear, and it issues a set and a clear to the same bit in one cycle to catch a design where the set wins. It also writes all ones to the reserved bits to catch storage that should not exist. Finally, it samples the request both before and after the capturing edge, so that a combinational or two-stage path shows up as a request that is early or late.

// File: rtl/lvl_mask_unit.sv
module lvl_mask_unit #(
  parameter int CODE_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_we,
  input  logic [2*(1<<CODE_W)-1:0]    set_data,
  input  logic                        clr_we,
  input  logic [2*(1<<CODE_W)-1:0]    clr_data,
  input  logic                        rd_sel,
  output logic [2*(1<<CODE_W)-1:0]    rd_data,
  input  logic                        g0_en,
  input  logic [CODE_W-1:0]           g0_code,
  input  logic                        g1_en,
  input  logic [CODE_W-1:0]           g1_code,
  output logic                        g0_req,
  output logic [CODE_W-1:0]           g0_level,
  output logic                        g1_req,
  output logic [CODE_W-1:0]           g1_level
);
  localparam int DATA_W = 2 * (1 << CODE_W);
  localparam int HALF   = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam logic [CODE_W-1:0] IDLE = '1;
  localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] VALID = ~((ONE << HALF) | ONE);

  logic [DATA_W-1:0] mask_q, mask_d;
  logic [IDX_W-1:0]  g0_idx, g1_idx;
  logic              g0_pass, g1_pass;

  assign mask_d = (mask_q | (set_we ? set_data : '0))
                & ~(clr_we ? clr_data : '0) & VALID;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;

  assign rd_data = rd_sel ? '0 : mask_q;

  assign g0_idx  = IDX_W'(DATA_W - 1) - IDX_W'(g0_code);
  assign g1_idx  = IDX_W'(HALF - 1)   - IDX_W'(g1_code);
  assign g0_pass = g0_en && (g0_code != IDLE) && !mask_q[g0_idx];
  assign g1_pass = g1_en && (g1_code != IDLE) && !mask_q[g1_idx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      g0_req   <= 1'b0;
      g1_req   <= 1'b0;
      g0_level <= IDLE;
      g1_level <= IDLE;
    end else begin
      g0_req   <= g0_pass;
      g1_req   <= g1_pass;
      g0_level <= g0_code;
      g1_level <= g1_code;
    end
endmodule

// File: rtl/lvl_mask_unit_chk.sv
module lvl_mask_unit_chk #(
  parameter int CODE_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     set_we,
  input logic [2*(1<<CODE_W)-1:0] set_data,
  input logic                     clr_we,
  input logic [2*(1<<CODE_W)-1:0] clr_data,
  input logic                     rd_sel,
  input logic [2*(1<<CODE_W)-1:0] rd_data,
  input logic                     g0_en,
  input logic [CODE_W-1:0]        g0_code,
  input logic                     g1_en,
  input logic [CODE_W-1:0]        g1_code,
  input logic                     g0_req,
  input logic [CODE_W-1:0]        g0_level,
  input logic                     g1_req,
  input logic [CODE_W-1:0]        g1_level,
  input logic [2*(1<<CODE_W)-1:0] mask_q
);
  localparam int DATA_W = 2 * (1 << CODE_W);
  localparam int HALF   = DATA_W / 2;
  localparam logic [CODE_W-1:0] IDLE = '1;
  localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] VALID = ~((ONE << HALF) | ONE);

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((mask_q & $past(set_data & VALID)) == $past(set_data & VALID)));

  assert_clear_applies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask_q & $past(clr_data)) == '0));

  assert_idle_writes_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(mask_q));

  assert_clear_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> (rd_data == '0));

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> (rd_data[HALF] == 1'b0 && rd_data[0] == 1'b0));

  assert_g0_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !g0_en |=> !g0_req);

  assert_g1_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !g1_en |=> !g1_req);

  assert_g0_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (g0_code == IDLE) |=> !g0_req);

  assert_g1_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (g1_code == IDLE) |=> !g1_req);

  assert_g0_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    g0_req |-> (g0_level != IDLE));

  assert_g1_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    g1_req |-> (g1_level != IDLE));
endmodule

bind lvl_mask_unit lvl_mask_unit_chk #(.CODE_W(CODE_W)) i_lvl_mask_unit_chk (.*);

// File: tb/test_lvl_mask_unit.sv
module test_lvl_mask_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_we = 1'b0, clr_we = 1'b0, rd_sel = 1'b0;
  logic [31:0] set_data = '0, clr_data = '0;
  logic [31:0] rd_data;
  logic        g0_en = 1'b0, g1_en = 1'b0;
  logic [3:0]  g0_code = 4'hF, g1_code = 4'hF;
  logic        g0_req, g1_req;
  logic [3:0]  g0_level, g1_level;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  lvl_mask_unit i_lvl_mask_unit (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_set(input logic [31:0] d);
    @(negedge clk); set_we = 1'b1; set_data = d;
    @(negedge clk); set_we = 1'b0; set_data = '0;
  endtask

  task automatic do_clr(input logic [31:0] d);
    @(negedge clk); clr_we = 1'b1; clr_data = d;
    @(negedge clk); clr_we = 1'b0; clr_data = '0;
  endtask

  task automatic read_mask(output logic [31:0] v);
    rd_sel = 1'b0; #1 v = rd_data;
  endtask

  task automatic present(input logic e0, input logic [3:0] c0, input logic e1, input logic [3:0] c1);
    @(negedge clk); g0_en = e0; g0_code = c0; g1_en = e1; g1_code = c1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    read_mask(v);             check("R1 mask after reset", v, 32'h0);
    rd_sel = 1'b1; #1;        check("R3 clear reg reads zero", rd_data, 32'h0);
    rd_sel = 1'b0;
    check("R1 g0_req idle after reset", {31'b0, g0_req}, 32'h0);
    check("R1 g1_req idle after reset", {31'b0, g1_req}, 32'h0);
  endtask

  task automatic t_set_clear();
    logic [31:0] v;
    do_set(32'hFFFF_FFFF);
    read_mask(v); check("R2 R7 set all, reserved stay 0", v, 32'hFFFE_FFFE);
    rd_sel = 1'b1; #1; check("R3 clear reg still reads zero", rd_data, 32'h0);
    rd_sel = 1'b0;
    do_set(32'h0);
    read_mask(v); check("R2 set write of zero is ignored", v, 32'hFFFE_FFFE);
    do_clr(32'h0);
    read_mask(v); check("R3 clear write of zero is ignored", v, 32'hFFFE_FFFE);
    do_clr(32'h00F0_0F00);
    read_mask(v); check("R3 partial clear", v, 32'hFF0E_F0FE);
    do_clr(32'hFFFF_FFFF);
    read_mask(v); check("R4 mask empty after full clear", v, 32'h0);
    do_set(32'h0001_0001);
    read_mask(v); check("R7 reserved bits ignore set", v, 32'h0);
  endtask

  task automatic t_map_g0();
    for (int n = 0; n < 15; n++) begin
      do_set(32'h1 << (31 - n));
      present(1'b1, 4'(n), 1'b0, 4'hF);
      check($sformatf("R5 g0 code %0d masked", n), {31'b0, g0_req}, 32'h0);
      present(1'b1, 4'((n + 1) % 15), 1'b0, 4'hF);
      check($sformatf("R5 g0 neighbour of %0d passes", n), {31'b0, g0_req}, 32'h1);
      check($sformatf("R10 g0 level after %0d", n), {28'b0, g0_level}, 32'((n + 1) % 15));
      do_clr(32'hFFFF_FFFF);
    end
  endtask

  task automatic t_map_g1();
    for (int n = 0; n < 15; n++) begin
      do_set(32'h1 << (15 - n));
      present(1'b1, 4'(n), 1'b1, 4'(n));
      check($sformatf("R6 g1 code %0d masked", n), {31'b0, g1_req}, 32'h0);
      check($sformatf("R6 g0 code %0d not affected by lower half", n), {31'b0, g0_req}, 32'h1);
      present(1'b0, 4'hF, 1'b1, 4'((n + 1) % 15));
      check($sformatf("R6 g1 neighbour of %0d passes", n), {31'b0, g1_req}, 32'h1);
      check($sformatf("R10 g1 level after %0d", n), {28'b0, g1_level}, 32'((n + 1) % 15));
      do_clr(32'hFFFF_FFFF);
    end
  endtask

  task automatic t_gate_idle();
    present(1'b0, 4'h3, 1'b0, 4'h5);
    check("R8 g0 disabled blocks request", {31'b0, g0_req}, 32'h0);
    check("R8 g1 disabled blocks request", {31'b0, g1_req}, 32'h0);
    present(1'b1, 4'hF, 1'b1, 4'hF);
    check("R9 g0 idle code gives no request", {31'b0, g0_req}, 32'h0);
    check("R9 g1 idle code gives no request", {31'b0, g1_req}, 32'h0);
  endtask

  task automatic t_timing();
    present(1'b0, 4'hF, 1'b0, 4'hF);
    @(negedge clk); g0_en = 1'b1; g0_code = 4'h7;
    #1 check("R10 no request before capturing edge", {31'b0, g0_req}, 32'h0);
    @(posedge clk); #1;
    check("R10 request one edge later", {31'b0, g0_req}, 32'h1);
    check("R10 level carried with request", {28'b0, g0_level}, 32'h7);
    @(negedge clk); g0_en = 1'b0;
    @(posedge clk); #1;
    check("R8 request drops one edge after disable", {31'b0, g0_req}, 32'h0);
  endtask

  task automatic t_clear_wins();
    logic [31:0] v;
    @(negedge clk);
    set_we = 1'b1; set_data = 32'h8000_0004;
    clr_we = 1'b1; clr_data = 32'h8000_0000;
    @(negedge clk);
    set_we = 1'b0; clr_we = 1'b0; set_data = '0; clr_data = '0;
    read_mask(v); check("R11 clear beats set on same bit", v, 32'h0000_0004);
    @(negedge clk);
    set_we = 1'b1; set_data = 32'h0000_0004;
    clr_we = 1'b1; clr_data = 32'h0000_0004;
    @(negedge clk);
    set_we = 1'b0; clr_we = 1'b0; set_data = '0; clr_data = '0;
    read_mask(v); check("R11 clear beats set on already set bit", v, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_map_g0();
    t_map_g1();
    t_gate_idle();
    t_timing();
    t_clear_wins();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule